// File: doc/BRIEF.md
# Expected-reaction scoreboard with timeouts

This block checks one output interface of a design under test against a stream of predicted results. A reference side pushes expected data words into a small pending store. Each word observed on the design's output is then matched against that store. Every pending word carries its own age counter. A word that nobody claims within its acceptance window is reported as missing and removed. Observed words are graded in three ways. A word with no candidate entry is unexpected. A word whose candidate differs in data, or that arrives before the minimum delay, is incorrect. Any other word passes and consumes its candidate.

Two matching policies can be chosen at run time. In-order mode offers only the oldest pending entry as the candidate. Adaptive mode uses the observed word itself to search the store and picks the oldest entry holding equal data, so a design that reorders its results still passes. The acceptance window is set by a minimum delay and a timeout counted beyond it. For example, a two-stage path with windows of 0..3 and 1..4 cycles gives a minimum delay of 1 and a timeout of 6, and these are the default values. Each checked interface gets its own instance.

Top module: `rxn_scoreboard`

## Requirements
- R1: After reset the store is empty (`pend_count` = 0), all pulse outputs are 0 and all three counters read 0.
- R2: When `exp_valid` is high and the store holds fewer than DEPTH entries, the word joins the store and `pend_count` rises by one after the clock edge. When the store already holds DEPTH entries in that cycle, the word is dropped and `overflow` is high for exactly the following cycle.
- R3: Let the delay d be the number of cycles from the push cycle to the reaction cycle. A reaction whose candidate has equal data and MIN_DLY <= d <= MIN_DLY+TMO raises no error pulse, and the candidate is consumed.
- R4: An entry not consumed by the reaction cycle at d = MIN_DLY+TMO is removed at that cycle's edge, and `miss_pulse` is high for one cycle, in the cycle at d = MIN_DLY+TMO+1.
- R5: A reaction with no candidate raises `unexp_pulse` in the next cycle and leaves the store unchanged. This covers an empty store, a store whose only entry was pushed in the same cycle, and adaptive mode with no equal entry.
- R6: With `adaptive` = 0, only the oldest entry is a candidate. A reaction whose data differs from it raises `wrong_pulse` in the next cycle and consumes that oldest entry.
- R7: With `adaptive` = 1, the candidate is the oldest entry whose data equals `obs_data`, so reactions in a different order than pushed pass. The other entries stay and keep their ages.
- R8: A reaction whose candidate has d < MIN_DLY raises `wrong_pulse` in the next cycle and consumes the candidate, in either mode.
- R9: Each pulse output increments its own counter at the same edge. Counters saturate at 2^CNT_W-1. `clr_cnt` zeroes all counters at the next edge and has priority over an increment.
- R10: `ambiguous` stays 0: candidate selection never yields more than one entry, even when several entries hold equal data.
- R11: When the oldest entry expires in the same cycle that a reaction consumes a different entry, both are removed. `miss_pulse` is reported and the reaction is graded on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_cnt | input | 1 | Synchronous clear of the three error counters |
| adaptive | input | 1 | Matching policy: 0 in-order, 1 adaptive search |
| exp_valid | input | 1 | Expected word present |
| exp_data | input | DATA_W | Expected word |
| obs_valid | input | 1 | Observed design reaction present |
| obs_data | input | DATA_W | Observed design reaction |
| miss_pulse | output | 1 | Missing-reaction error, one cycle |
| unexp_pulse | output | 1 | Unexpected-reaction error, one cycle |
| wrong_pulse | output | 1 | Incorrect-reaction error, one cycle |
| miss_count | output | CNT_W | Saturating count of missing reactions |
| unexp_count | output | CNT_W | Saturating count of unexpected reactions |
| wrong_count | output | CNT_W | Saturating count of incorrect reactions |
| pend_count | output | $clog2(DEPTH+1) | Entries currently pending |
| overflow | output | 1 | Push dropped because the store was full, one cycle |
| ambiguous | output | 1 | More than one candidate selected (internal consistency flag) |

## Verification
The bench builds the block with DEPTH=4, MIN_DLY=2, TMO=3 and CNT_W=4. With these values the store fills after four pushes, and every reaction delay from 0 to one past the last acceptable cycle can be swept in a few dozen cycles. That sweep covers the early, in-window, deadline and late cases. A 4-bit counter saturates after fifteen unexpected reactions, so saturation and clear priority are reachable. With the short window, a head expiry can be lined up in the same cycle as an adaptive match on a younger entry.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  typedef enum logic {
    MODE_INORDER  = 1'b0,
    MODE_ADAPTIVE = 1'b1
  } match_mode_e;

  localparam int ERR_MISS  = 0;
  localparam int ERR_UNEXP = 1;
  localparam int ERR_WRONG = 2;
  localparam int N_ERR     = 3;
endpackage

// File: rtl/sb_sat_cnt.sv
`timescale 1ns/1ps
module sb_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    if (clr)
      cnt_d = '0;
    else if (cnt_q != MAX)
      cnt_d = cnt_q + W'(1);
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R9: a full counter holds when not cleared
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt_q == MAX) |=> cnt_q == MAX);
  // R9: clear wins over increment
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
  // R9: an increment below the limit adds exactly one
  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && cnt_q != MAX) |=> cnt_q == $past(cnt_q) + W'(1));
endmodule

// File: rtl/sb_pick.sv
`timescale 1ns/1ps
module sb_pick
  import sb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8
) (
  input  match_mode_e                   mode,
  input  logic [DEPTH-1:0]              vld,
  input  logic [DEPTH-1:0][DATA_W-1:0]  dat,
  input  logic [DATA_W-1:0]             obs_data,
  output logic [DEPTH-1:0]              cand,
  output logic                          ambiguous
);
  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign hit[i] = vld[i] && (dat[i] == obs_data);
  end

  always_comb begin
    cand = '0;
    if (mode == MODE_INORDER)
      cand[0] = vld[0];
    else
      cand = hit & (~hit + DEPTH'(1));   // lowest set bit = oldest equal entry
    ambiguous = ($countones(cand) > 1);
  end
endmodule

// File: rtl/sb_store.sv
`timescale 1ns/1ps
module sb_store #(
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 8,
  parameter int LAST_OK = 7,
  parameter int AGE_W   = 3,
  parameter int PC_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [DATA_W-1:0]             push_data,
  input  logic [DEPTH-1:0]              take,
  output logic [DEPTH-1:0]              vld,
  output logic [DEPTH-1:0][DATA_W-1:0]  dat,
  output logic [DEPTH-1:0][AGE_W-1:0]   age,
  output logic [PC_W-1:0]               count,
  output logic                          expire,
  output logic                          drop
);
  logic [DEPTH-1:0]             vld_q, vld_d, keep;
  logic [DEPTH-1:0][DATA_W-1:0] dat_q, dat_d;
  logic [DEPTH-1:0][AGE_W-1:0]  age_q, age_d;
  logic                         full;

  always_comb begin
    int unsigned pos;
    full   = &vld_q;
    drop   = push && full;
    expire = vld_q[0] && (age_q[0] == AGE_W'(LAST_OK)) && !take[0];
    keep   = vld_q & ~take;
    if (expire) keep[0] = 1'b0;
    vld_d = '0;
    dat_d = '0;
    age_d = '0;
    pos   = 0;
    // compact survivors toward slot 0, oldest first
    for (int j = 0; j < DEPTH; j++) begin
      if (keep[j]) begin
        vld_d[pos] = 1'b1;
        dat_d[pos] = dat_q[j];
        age_d[pos] = age_q[j] + AGE_W'(1);
        pos++;
      end
    end
    if (push && !full) begin
      vld_d[pos] = 1'b1;
      dat_d[pos] = push_data;
      age_d[pos] = AGE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dat_q <= '0;
      age_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
      age_q <= age_d;
    end
  end

  assign vld   = vld_q;
  assign dat   = dat_q;
  assign age   = age_q;
  assign count = PC_W'($countones(vld_q));

  // R4: no pending entry outlives its window
  a_r4_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q[0] |-> age_q[0] <= AGE_W'(LAST_OK));
  // R2: a dropped push never grows the store
  a_r2_drop_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> count <= $past(count));

  for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_order
    // R7: entries stay packed and ordered oldest first
    a_r7_packed: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[i+1] |-> vld_q[i]);
    a_r7_age_order: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[i+1] |-> age_q[i] > age_q[i+1]);
  end
endmodule

// File: rtl/rxn_scoreboard.sv
`timescale 1ns/1ps
module rxn_scoreboard
  import sb_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 8,
  parameter int MIN_DLY = 1,
  parameter int TMO     = 6,
  parameter int CNT_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_cnt,
  input  logic                       adaptive,
  input  logic                       exp_valid,
  input  logic [DATA_W-1:0]          exp_data,
  input  logic                       obs_valid,
  input  logic [DATA_W-1:0]          obs_data,
  output logic                       miss_pulse,
  output logic                       unexp_pulse,
  output logic                       wrong_pulse,
  output logic [CNT_W-1:0]           miss_count,
  output logic [CNT_W-1:0]           unexp_count,
  output logic [CNT_W-1:0]           wrong_count,
  output logic [$clog2(DEPTH+1)-1:0] pend_count,
  output logic                       overflow,
  output logic                       ambiguous
);
  localparam int LAST_OK = MIN_DLY + TMO;
  localparam int AGE_W   = $clog2(LAST_OK + 1);
  localparam int PC_W    = $clog2(DEPTH + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  match_mode_e                  mode;
  logic [DEPTH-1:0]             vld, cand, take;
  logic [DEPTH-1:0][DATA_W-1:0] dat;
  logic [DEPTH-1:0][AGE_W-1:0]  age;
  logic [DATA_W-1:0]            cand_dat;
  logic [AGE_W-1:0]             cand_age;
  logic                         found, expire, drop;
  logic [N_ERR-1:0]             err_d, err_q;
  logic                         ovf_q;
  logic [CNT_W-1:0]             cnt_arr [N_ERR];

  assign mode = adaptive ? MODE_ADAPTIVE : MODE_INORDER;

  sb_pick #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_pick (
    .mode      (mode),
    .vld       (vld),
    .dat       (dat),
    .obs_data  (obs_data),
    .cand      (cand),
    .ambiguous (ambiguous)
  );

  sb_store #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .LAST_OK(LAST_OK),
    .AGE_W(AGE_W), .PC_W(PC_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (exp_valid),
    .push_data (exp_data),
    .take      (take),
    .vld       (vld),
    .dat       (dat),
    .age       (age),
    .count     (pend_count),
    .expire    (expire),
    .drop      (drop)
  );

  always_comb begin
    found    = |cand;
    take     = obs_valid ? cand : '0;
    cand_dat = '0;
    cand_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i]) begin
        cand_dat = cand_dat | dat[i];
        cand_age = cand_age | age[i];
      end
    end
    err_d            = '0;
    err_d[ERR_MISS]  = expire;
    err_d[ERR_UNEXP] = obs_valid && !found;
    err_d[ERR_WRONG] = obs_valid && found &&
                       ((cand_dat != obs_data) || (cand_age < AGE_W'(MIN_DLY)));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      err_q <= err_d;
      ovf_q <= drop;
    end
  end

  for (genvar k = 0; k < N_ERR; k++) begin : g_cnt
    sb_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (clr_cnt),
      .inc   (err_d[k]),
      .cnt   (cnt_arr[k])
    );
  end

  assign miss_pulse  = err_q[ERR_MISS];
  assign unexp_pulse = err_q[ERR_UNEXP];
  assign wrong_pulse = err_q[ERR_WRONG];
  assign miss_count  = cnt_arr[ERR_MISS];
  assign unexp_count = cnt_arr[ERR_UNEXP];
  assign wrong_count = cnt_arr[ERR_WRONG];
  assign overflow    = ovf_q;

  // R10: at most one candidate ever
  a_r10_single_candidate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ambiguous);
  // R5 / R6: one reaction gets one grade
  a_r5_grade_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(unexp_pulse && wrong_pulse));
  // R5: a reaction against an empty store is unexpected
  a_r5_empty_unexpected: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (obs_valid && pend_count == '0) |=> unexp_pulse);
  // R4: a miss needs a pending entry before it
  a_r4_miss_had_entry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    miss_pulse |-> $past(pend_count) != '0);
  // R2: overflow only follows a full store
  a_r2_overflow_full: assert property (@(posedge clk) disable iff (!rst_sync_n)
    overflow |-> $past(pend_count) == PC_W'(DEPTH));
endmodule

// File: tb/rxn_scoreboard_tb.sv
`timescale 1ns/1ps
module rxn_scoreboard_tb;
  localparam int DW   = 8;
  localparam int DEP  = 4;
  localparam int MIN  = 2;
  localparam int TMO  = 3;
  localparam int CW   = 4;
  localparam int LAST = MIN + TMO;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n, clr_cnt, adaptive;
  logic          exp_valid, obs_valid;
  logic [DW-1:0] exp_data, obs_data;
  logic          miss_pulse, unexp_pulse, wrong_pulse, overflow, ambiguous;
  logic [CW-1:0] miss_count, unexp_count, wrong_count;
  logic [$clog2(DEP+1)-1:0] pend_count;

  int  checks = 0, failures = 0;
  int  m_mis = 0, m_unx = 0, m_inc = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  rxn_scoreboard #(
    .DATA_W(DW), .DEPTH(DEP), .MIN_DLY(MIN), .TMO(TMO), .CNT_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_cnt(clr_cnt), .adaptive(adaptive),
    .exp_valid(exp_valid), .exp_data(exp_data),
    .obs_valid(obs_valid), .obs_data(obs_data),
    .miss_pulse(miss_pulse), .unexp_pulse(unexp_pulse), .wrong_pulse(wrong_pulse),
    .miss_count(miss_count), .unexp_count(unexp_count), .wrong_count(wrong_count),
    .pend_count(pend_count), .overflow(overflow), .ambiguous(ambiguous)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  // drive one cycle, then check the pulses produced by its edge
  task automatic tick(input bit ev, input logic [DW-1:0] ed,
                      input bit ov, input logic [DW-1:0] od,
                      input bit em, input bit eu, input bit ei, input string req);
    exp_valid = ev; exp_data = ed; obs_valid = ov; obs_data = od;
    @(negedge clk);
    chk({req, " miss"},  int'(miss_pulse),  int'(em));
    chk({req, " unexp"}, int'(unexp_pulse), int'(eu));
    chk({req, " wrong"}, int'(wrong_pulse), int'(ei));
    chk("R10 ambiguous", int'(ambiguous), 0);
    if (!clr_cnt) begin
      if (em) m_mis = sat(m_mis);
      if (eu) m_unx = sat(m_unx);
      if (ei) m_inc = sat(m_inc);
    end
  endtask

  task automatic idle(input bit em, input string req);
    tick(1'b0, '0, 1'b0, '0, em, 1'b0, 1'b0, req);
  endtask

  task automatic chk_cnts(input string req);
    chk({req, " miss_count"},  int'(miss_count),  m_mis);
    chk({req, " unexp_count"}, int'(unexp_count), m_unx);
    chk({req, " wrong_count"}, int'(wrong_count), m_inc);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr_cnt = 1'b0; adaptive = 1'b0;
    exp_valid = 1'b0; obs_valid = 1'b0; exp_data = '0; obs_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pend", int'(pend_count), 0);
    chk("R1 pulses", int'(miss_pulse | unexp_pulse | wrong_pulse | overflow), 0);
    chk_cnts("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pend after release", int'(pend_count), 0);

    // delay sweep, in-order mode: R3 in window, R8 early, R4 late
    for (int d = 1; d <= LAST + 1; d++) begin
      string rq;
      rq = (d < MIN) ? "R8" : ((d > LAST) ? "R4" : "R3");
      tick(1'b1, DW'(8'h10 + d), 1'b0, '0, 1'b0, 1'b0, 1'b0, "R2 push");
      chk("R2 pend after push", int'(pend_count), 1);
      for (int i = 1; i < d; i++) idle(i == LAST, rq);
      tick(1'b0, '0, 1'b1, DW'(8'h10 + d), 1'b0, d > LAST, d < MIN, rq);
      chk({rq, " pend after reaction"}, int'(pend_count), 0);
    end

    // R5: reaction in the push cycle finds nothing; entry then expires (R4)
    tick(1'b1, 8'hA5, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b0, "R5 same cycle");
    chk("R5 store unchanged", int'(pend_count), 1);
    for (int i = 1; i <= LAST; i++) idle(i == LAST, "R4 expiry");
    chk("R4 removed", int'(pend_count), 0);

    // R6: in-order data mismatch consumes the oldest
    tick(1'b1, 8'h21, 1'b0, '0, 0, 0, 0, "R6 push a");
    tick(1'b1, 8'h22, 1'b0, '0, 0, 0, 0, "R6 push b");
    idle(1'b0, "R6");
    tick(1'b0, '0, 1'b1, 8'h22, 1'b0, 1'b0, 1'b1, "R6 mismatch");
    chk("R6 oldest consumed", int'(pend_count), 1);
    tick(1'b0, '0, 1'b1, 8'h22, 1'b0, 1'b0, 1'b0, "R6 next ok");
    chk("R6 pend", int'(pend_count), 0);
    chk_cnts("R9 after in-order");

    // R7: adaptive accepts reversed order
    adaptive = 1'b1;
    tick(1'b1, 8'h31, 1'b0, '0, 0, 0, 0, "R7 push a");
    tick(1'b1, 8'h32, 1'b0, '0, 0, 0, 0, "R7 push b");
    idle(1'b0, "R7");
    tick(1'b0, '0, 1'b1, 8'h32, 1'b0, 1'b0, 1'b0, "R7 b first");
    chk("R7 one left", int'(pend_count), 1);
    tick(1'b0, '0, 1'b1, 8'h31, 1'b0, 1'b0, 1'b0, "R7 a second");
    chk("R7 empty", int'(pend_count), 0);

    // R5: adaptive with no equal entry leaves the store alone
    tick(1'b1, 8'h41, 1'b0, '0, 0, 0, 0, "R5 push");
    idle(1'b0, "R5");
    idle(1'b0, "R5");
    tick(1'b0, '0, 1'b1, 8'h55, 1'b0, 1'b1, 1'b0, "R5 no match");
    chk("R5 store unchanged", int'(pend_count), 1);
    tick(1'b0, '0, 1'b1, 8'h41, 1'b0, 1'b0, 1'b0, "R7 late match ok");
    chk("R7 pend", int'(pend_count), 0);

    // R7/R10: duplicates, oldest chosen; the survivor expires one cycle later
    tick(1'b1, 8'h44, 1'b0, '0, 0, 0, 0, "R7 dup a");
    tick(1'b1, 8'h44, 1'b0, '0, 0, 0, 0, "R7 dup b");
    tick(1'b0, '0, 1'b0, 8'h44, 0, 0, 0, "R10 two equal");
    tick(1'b0, '0, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0, "R7 dup match");
    chk("R7 survivor", int'(pend_count), 1);
    idle(1'b0, "R7 survivor is younger");
    idle(1'b0, "R7 survivor is younger");
    idle(1'b1, "R7 survivor expiry");
    chk("R7 pend", int'(pend_count), 0);

    // R8: early in adaptive mode
    tick(1'b1, 8'h46, 1'b0, '0, 0, 0, 0, "R8 push");
    tick(1'b0, '0, 1'b1, 8'h46, 1'b0, 1'b0, 1'b1, "R8 early adaptive");
    chk("R8 consumed", int'(pend_count), 0);

    // R11: head expires while a younger entry is matched
    tick(1'b1, 8'h51, 1'b0, '0, 0, 0, 0, "R11 push a");
    tick(1'b1, 8'h52, 1'b0, '0, 0, 0, 0, "R11 push b");
    for (int i = 2; i < LAST; i++) idle(1'b0, "R11");
    tick(1'b0, '0, 1'b1, 8'h52, 1'b1, 1'b0, 1'b0, "R11 expire and match");
    chk("R11 both removed", int'(pend_count), 0);

    // R2: overflow, then the four stored entries expire in turn (R4)
    for (int k = 0; k <= DEP; k++) begin
      tick(1'b1, DW'(8'h60 + k), 1'b0, '0, 0, 0, 0, "R2 fill");
      chk("R2 pend", int'(pend_count), (k < DEP) ? k + 1 : DEP);
      chk("R2 overflow", int'(overflow), (k == DEP) ? 1 : 0);
    end
    for (int j = DEP + 1; j <= DEP + 5; j++) begin
      idle(j >= LAST && j < LAST + DEP, "R4 drain");
      chk("R2 overflow one cycle", int'(overflow), 0);
    end
    chk("R4 drained", int'(pend_count), 0);
    chk_cnts("R9 mid");

    // R9: saturation, then clear with priority over increment
    adaptive = 1'b0;
    for (int k = 0; k < CMAX + 4; k++)
      tick(1'b0, '0, 1'b1, 8'h77, 1'b0, 1'b1, 1'b0, "R5 empty store");
    chk("R9 saturated", int'(unexp_count), CMAX);
    chk_cnts("R9 saturated");
    clr_cnt = 1'b1;
    tick(1'b0, '0, 1'b1, 8'h77, 1'b0, 1'b1, 1'b0, "R9 clear");
    clr_cnt = 1'b0;
    m_mis = 0; m_unx = 0; m_inc = 0;
    chk_cnts("R9 cleared");
    tick(1'b0, '0, 1'b1, 8'h78, 1'b0, 1'b1, 1'b0, "R9 count again");
    chk("R9 restart", int'(unexp_count), 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule